// File: doc/BRIEF.md
# Two-Master Bus Lock Arbiter

This block decides which of two upstream masters owns a single shared downstream serial bus. Each master presents a lock request, a connect bit, a priority bit, an idle-disconnect enable, manual pin values and a write port for its own reserve time. The arbiter keeps at most one grant at a time. It shows each master whether the opposite side holds the bus. It closes the bus switch for the owner only when that owner also asks to be connected.

When a grant is given, a reserve counter is loaded from the owner's reserve time and counts down in units of `TICKS_PER_MS` clock cycles. After it reaches zero, or straight away if it was loaded with zero, an optional idle timer can take the bus back. This happens when the downstream bus has been idle for `IDLE_MS * TICKS_PER_MS` cycles. The master that loses the bus this way gets a one-cycle bus-lost pulse. It cannot be granted again until it drops its request and raises it again. An owner that holds the grant with its switch open can drive the downstream clock and data lines by hand and read their levels back.

Top module: `bus_lock_arbiter`

## Requirements
- R1: While reset is held and after it, both grants, both switch enables, both bus-lost flags and both other-lock bits are 0, and neither pin is driven low.
- R2: With no current owner, a master that raises its request is granted on the next clock edge. On that edge `rsv_left_o` takes that master's stored reserve time.
- R3: When both masters request at the same edge with no owner, master 1 wins only if `prio_i[1]`=1 and `prio_i[0]`=0. Otherwise master 0 wins.
- R4: Both grant bits are never 1 together. A request from the non-owner waits until the owner's grant falls, and is granted on the edge after that.
- R5: An owner that clears its request loses the grant on the next edge, with no bus-lost pulse.
- R6: `sw_en_o[k]` is 1 exactly when master k holds the grant and `conn_i[k]`=1.
- R7: `other_lock_o[k]` is 1 exactly when the opposite master holds the grant.
- R8: A reserve-time write from master k is ignored while master k holds the grant. Otherwise it is stored and used on its next grant.
- R9: While a grant is held, `rsv_left_o` decreases by one every `TICKS_PER_MS` cycles, counted from the grant edge, and stops at 0.
- R10: With idle-disconnect enabled for the owner, the grant is revoked after the reserve reaches 0 and `bus_idle_i` has then been 1 for `IDLE_MS*TICKS_PER_MS` consecutive cycles. Any non-idle cycle restarts that count. On the revoking edge, `bus_lost_o` for that master pulses for exactly one cycle.
- R11: A master whose grant was revoked is not granted again while its request stays 1. The other master may be granted in the meantime. Dropping the request and raising it again makes the revoked master eligible once more.
- R12: With idle-disconnect disabled for the owner, an idle bus never revokes the grant.
- R13: Hand control applies only for a master with grant 1 and connect 0. A 0 in its `man_scl_i`/`man_sda_i` bit drives that line low, and a 1 releases it. Its `scl_rd_o`/`sda_rd_o` bit shows the line level and reads 0 otherwise. The bits of other masters have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 2 | Lock request per master |
| conn_i | input | 2 | Connect request per master |
| prio_i | input | 2 | Priority bit per master for simultaneous requests |
| idle_en_i | input | 2 | Idle-disconnect enable per master |
| rt_wr_i | input | 2 | Reserve-time write strobe per master |
| rt_wdata_i | input | 2*RES_W | Reserve-time write data, master k in bits [k*RES_W +: RES_W] |
| bus_idle_i | input | 1 | Downstream bus idle indication |
| man_scl_i | input | 2 | Hand-driven clock line value per master |
| man_sda_i | input | 2 | Hand-driven data line value per master |
| scl_in_i | input | 1 | Downstream clock line level |
| sda_in_i | input | 1 | Downstream data line level |
| grant_o | output | 2 | Grant per master |
| other_lock_o | output | 2 | Opposite master owns the bus |
| sw_en_o | output | 2 | Bus switch closed for master k |
| bus_lost_o | output | 2 | One-cycle pulse on involuntary loss |
| rsv_left_o | output | RES_W | Reserve time remaining for the owner |
| scl_drv_low_o | output | 1 | Pull downstream clock line low |
| sda_drv_low_o | output | 1 | Pull downstream data line low |
| scl_rd_o | output | 2 | Clock line readback per master |
| sda_rd_o | output | 2 | Data line readback per master |

## Verification
The bench targets the simultaneous-request tie under every priority pattern. A swapped or inverted tie rule would hand the bus to the wrong master. It times the reserve countdown and the idle revocation edge by edge, so an off-by-one counter or an idle timer that runs before the reserve expires shows up as a grant that falls early or late. It checks that a revoked master with its request still high is locked out while the other master is served, since a missing lock-out would regrant it at once. It also checks that reserve writes during ownership are dropped and that a non-idle cycle restarts the idle count.

// File: rtl/bla_pkg.sv
// Shared helpers for the two-master bus lock arbiter.
// Assumes exactly two masters, indexed 0 and 1.
package bla_pkg;
    localparam int NUM_M = 2;

    // Winner of a simultaneous request: master 1 only if it alone has priority
    function automatic logic tie_winner(input logic [1:0] prio);
        return prio[1] & ~prio[0];
    endfunction
endpackage

// File: rtl/bla_tick_gen.sv
// Millisecond tick prescaler. Emits tick_o once every TICKS cycles; restart_i
// realigns the count so the first tick falls TICKS cycles after a grant edge.
// Assumes TICKS >= 2.
module bla_tick_gen #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Free-running modulo-TICKS counter with restart
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (restart_i)   cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/bla_lock_core.sv
// Grant state for two masters: arbitration with priority tie-break, voluntary
// release, reserve countdown, idle-timeout revocation and re-request lock-out.
// Assumes req_i is synchronous to clk and tick_i comes from bla_tick_gen.
module bla_lock_core
    import bla_pkg::*;
#(
    parameter int RES_W    = 8,
    parameter int IDLE_CYC = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         req_i,
    input  logic [1:0]         prio_i,
    input  logic [1:0]         idle_en_i,
    input  logic [1:0]         rt_wr_i,
    input  logic [2*RES_W-1:0] rt_wdata_i,
    input  logic               bus_idle_i,
    input  logic               tick_i,
    output logic [1:0]         gnt_o,
    output logic [1:0]         lost_o,
    output logic               load_o,
    output logic [RES_W-1:0]   rsv_o
);
    localparam int IW = $clog2(IDLE_CYC);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

    logic [1:0]       gnt_q, lost_q, blk_q;
    logic [RES_W-1:0] res_q;
    logic [IW-1:0]    idle_q;
    logic [RES_W-1:0] rt_q [NUM_M];

    logic [1:0] eff_req;
    logic       win, held, own, own_req, idle_arm, revoke, release_now;

    // Arbitration and ownership decode
    always_comb begin
        eff_req     = req_i & ~blk_q;
        held        = |gnt_q;
        own         = gnt_q[1];
        own_req     = req_i[own];
        load_o      = !held && (|eff_req);
        win         = (eff_req == 2'b11) ? tie_winner(prio_i) : eff_req[1];
        idle_arm    = held && idle_en_i[own] && (res_q == '0) && bus_idle_i;
        revoke      = idle_arm && own_req && (idle_q == IDLE_LAST);
        release_now = held && !own_req;
    end

    // Grant, reserve counter, bus-lost pulse and lock-out flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            lost_q <= '0;
            blk_q  <= '0;
            res_q  <= '0;
        end else begin
            lost_q <= '0;
            for (int k = 0; k < NUM_M; k++)
                if (!req_i[k]) blk_q[k] <= 1'b0;
            if (load_o) begin
                gnt_q <= win ? 2'b10 : 2'b01;
                res_q <= rt_q[win];
            end else if (release_now) begin
                gnt_q <= '0;
                res_q <= '0;
            end else if (revoke) begin
                gnt_q       <= '0;
                res_q       <= '0;
                lost_q[own] <= 1'b1;
                blk_q[own]  <= 1'b1;
            end else if (held && (res_q != '0) && tick_i) begin
                res_q <= res_q - 1'b1;
            end
        end
    end

    // Idle period counter, armed once the reserve has run out
    always_ff @(posedge clk) begin
        if (!rst_n)                   idle_q <= '0;
        else if (idle_arm && !revoke) idle_q <= idle_q + 1'b1;
        else                          idle_q <= '0;
    end

    // Per-master reserve-time registers, write-protected while granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_M; k++) rt_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_M; k++)
                if (rt_wr_i[k] && !gnt_q[k]) rt_q[k] <= rt_wdata_i[k*RES_W +: RES_W];
        end
    end

    assign gnt_o  = gnt_q;
    assign lost_o = lost_q;
    assign rsv_o  = res_q;

    // R4
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_q[0] && gnt_q[1]));

    // R3
    tie_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == 2'b00 && req_i == 2'b11 && blk_q == 2'b00 && prio_i == 2'b10)
        |=> gnt_q == 2'b10);

    // R4
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == 2'b01 && req_i[0] && !revoke) |=> gnt_q == 2'b01);

    generate
        for (genvar k = 0; k < NUM_M; k++) begin : g_chk
            // R5
            release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_q[k] && !req_i[k]) |=> (!gnt_q[k] && !lost_q[k]));
            // R2
            grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gnt_q[k]) |-> $past(req_i[k]));
            // R10
            lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lost_q[k] |-> ($past(gnt_q[k]) && $past(req_i[k]) && !gnt_q[k]));
            // R8
            rt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_q[k] |=> $stable(rt_q[k]));
        end
    endgenerate
endmodule

// File: rtl/bla_pin_ctrl.sv
// Bus switch enables, other-lock status and hand control of the downstream
// lines. Hand control belongs to a master holding the grant with connect low.
// Assumes gnt_i is one-hot or zero.
module bla_pin_ctrl
    import bla_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gnt_i,
    input  logic [1:0] conn_i,
    input  logic [1:0] man_scl_i,
    input  logic [1:0] man_sda_i,
    input  logic       scl_in_i,
    input  logic       sda_in_i,
    output logic [1:0] sw_en_o,
    output logic [1:0] other_lock_o,
    output logic       scl_low_o,
    output logic       sda_low_o,
    output logic [1:0] scl_rd_o,
    output logic [1:0] sda_rd_o
);
    logic [1:0] man_act;

    // Per-master switch, status and readback
    always_comb begin
        for (int k = 0; k < NUM_M; k++) begin
            man_act[k]      = gnt_i[k] & ~conn_i[k];
            sw_en_o[k]      = gnt_i[k] & conn_i[k];
            other_lock_o[k] = gnt_i[1-k];
            scl_rd_o[k]     = man_act[k] & scl_in_i;
            sda_rd_o[k]     = man_act[k] & sda_in_i;
        end
        scl_low_o = |(man_act & ~man_scl_i);
        sda_low_o = |(man_act & ~man_sda_i);
    end

    // R13
    manual_vs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low_o || sda_low_o) |-> (sw_en_o == 2'b00));

    // R6
    switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_en_o));
endmodule

// File: rtl/bus_lock_arbiter.sv
// Top of the two-master bus lock arbiter. Joins the tick prescaler, the lock
// core and the pin control. Assumes all inputs are synchronous to clk.
module bus_lock_arbiter #(
    parameter int RES_W        = 8,
    parameter int TICKS_PER_MS = 4,
    parameter int IDLE_MS      = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         req_i,
    input  logic [1:0]         conn_i,
    input  logic [1:0]         prio_i,
    input  logic [1:0]         idle_en_i,
    input  logic [1:0]         rt_wr_i,
    input  logic [2*RES_W-1:0] rt_wdata_i,
    input  logic               bus_idle_i,
    input  logic [1:0]         man_scl_i,
    input  logic [1:0]         man_sda_i,
    input  logic               scl_in_i,
    input  logic               sda_in_i,
    output logic [1:0]         grant_o,
    output logic [1:0]         other_lock_o,
    output logic [1:0]         sw_en_o,
    output logic [1:0]         bus_lost_o,
    output logic [RES_W-1:0]   rsv_left_o,
    output logic               scl_drv_low_o,
    output logic               sda_drv_low_o,
    output logic [1:0]         scl_rd_o,
    output logic [1:0]         sda_rd_o
);
    localparam int IDLE_CYC = IDLE_MS * TICKS_PER_MS;

    logic tick, load;

    bla_tick_gen #(.TICKS(TICKS_PER_MS)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .tick_o    (tick)
    );

    bla_lock_core #(.RES_W(RES_W), .IDLE_CYC(IDLE_CYC)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .prio_i     (prio_i),
        .idle_en_i  (idle_en_i),
        .rt_wr_i    (rt_wr_i),
        .rt_wdata_i (rt_wdata_i),
        .bus_idle_i (bus_idle_i),
        .tick_i     (tick),
        .gnt_o      (grant_o),
        .lost_o     (bus_lost_o),
        .load_o     (load),
        .rsv_o      (rsv_left_o)
    );

    bla_pin_ctrl u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt_i        (grant_o),
        .conn_i       (conn_i),
        .man_scl_i    (man_scl_i),
        .man_sda_i    (man_sda_i),
        .scl_in_i     (scl_in_i),
        .sda_in_i     (sda_in_i),
        .sw_en_o      (sw_en_o),
        .other_lock_o (other_lock_o),
        .scl_low_o    (scl_drv_low_o),
        .sda_low_o    (sda_drv_low_o),
        .scl_rd_o     (scl_rd_o),
        .sda_rd_o     (sda_rd_o)
    );

    // R7
    other_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[0] |-> (other_lock_o == 2'b10));

    // R6
    switch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o & ~grant_o) == 2'b00);
endmodule

// File: tb/sim_bus_lock_arbiter.sv
module sim_bus_lock_arbiter;
    localparam int RES_W = 8;
    localparam int TPM   = 4;
    localparam int IDLE  = 100 * TPM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req = 0, conn = 0, prio = 0, idle_en = 0, rt_wr = 0;
    logic [2*RES_W-1:0] rt_wdata = 0;
    logic bus_idle = 0;
    logic [1:0] man_scl = 2'b11, man_sda = 2'b11;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic [1:0] grant, other_lock, sw_en, lost, scl_rd, sda_rd;
    logic [RES_W-1:0] rsv;
    logic scl_low, sda_low;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_lock_arbiter #(.RES_W(RES_W), .TICKS_PER_MS(TPM), .IDLE_MS(100)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .conn_i(conn), .prio_i(prio),
        .idle_en_i(idle_en), .rt_wr_i(rt_wr), .rt_wdata_i(rt_wdata),
        .bus_idle_i(bus_idle), .man_scl_i(man_scl), .man_sda_i(man_sda),
        .scl_in_i(scl_in), .sda_in_i(sda_in), .grant_o(grant),
        .other_lock_o(other_lock), .sw_en_o(sw_en), .bus_lost_o(lost),
        .rsv_left_o(rsv), .scl_drv_low_o(scl_low), .sda_drv_low_o(sda_low),
        .scl_rd_o(scl_rd), .sda_rd_o(sda_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_rt(input int m, input logic [RES_W-1:0] v);
        rt_wdata[m*RES_W +: RES_W] = v;
        rt_wr[m] = 1'b1;
        wait_n(1);
        rt_wr = 2'b00;
    endtask

    task automatic drop_all();
        req = 2'b00;
        wait_n(2);
    endtask

    task automatic t_reset();
        chk("R1 grant in reset", grant, 2'b00);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 grant", grant, 2'b00);
        chk("R1 sw_en", sw_en, 2'b00);
        chk("R1 lost", lost, 2'b00);
        chk("R1 other_lock", other_lock, 2'b00);
        chk("R1 pins", {scl_low, sda_low}, 2'b00);
    endtask

    task automatic t_single();
        write_rt(0, 8'd5);
        req[0] = 1'b1;
        wait_n(1);
        chk("R2 grant m0", grant, 2'b01);
        chk("R2 rsv loaded", rsv, 8'd5);
        chk("R7 other_lock", other_lock, 2'b10);
        req[0] = 1'b0;
        wait_n(1);
        chk("R5 release", grant, 2'b00);
        chk("R5 no lost", lost, 2'b00);
        chk("R7 other_lock idle", other_lock, 2'b00);
        wait_n(1);
    endtask

    task automatic t_tie();
        prio = 2'b00; req = 2'b11; wait_n(1);
        chk("R3 tie prio00", grant, 2'b01);
        drop_all();
        prio = 2'b10; req = 2'b11; wait_n(1);
        chk("R3 tie prio m1", grant, 2'b10);
        chk("R7 other_lock m1", other_lock, 2'b01);
        drop_all();
        prio = 2'b11; req = 2'b11; wait_n(1);
        chk("R3 tie prio11", grant, 2'b01);
        drop_all();
        prio = 2'b01; req = 2'b11; wait_n(1);
        chk("R3 tie prio m0", grant, 2'b01);
        drop_all();
        prio = 2'b00;
    endtask

    task automatic t_wait();
        req = 2'b01; wait_n(1);
        req = 2'b11; wait_n(3);
        chk("R4 owner kept", grant, 2'b01);
        req = 2'b10; wait_n(1);
        chk("R4 gap after release", grant, 2'b00);
        wait_n(1);
        chk("R4 waiter granted", grant, 2'b10);
        drop_all();
    endtask

    task automatic t_rsv_write();
        write_rt(0, 8'd5);
        req = 2'b01; wait_n(1);
        write_rt(0, 8'd9);
        drop_all();
        req = 2'b01; wait_n(1);
        chk("R8 write while granted ignored", rsv, 8'd5);
        drop_all();
        write_rt(0, 8'd9);
        req = 2'b01; wait_n(1);
        chk("R8 write while free stored", rsv, 8'd9);
        drop_all();
    endtask

    task automatic t_switch();
        req = 2'b10; conn = 2'b10; wait_n(1);
        chk("R6 switch m1", sw_en, 2'b10);
        conn = 2'b01; wait_n(1);
        chk("R6 non-owner connect", sw_en, 2'b00);
        conn = 2'b00;
        drop_all();
    endtask

    task automatic t_manual();
        req = 2'b01; conn = 2'b00; man_scl = 2'b10; man_sda = 2'b01;
        scl_in = 1'b0; sda_in = 1'b1;
        wait_n(1);
        chk("R13 scl driven low", scl_low, 1'b1);
        chk("R13 sda other master ignored", sda_low, 1'b0);
        chk("R13 scl readback", scl_rd, 2'b00);
        chk("R13 sda readback", sda_rd, 2'b01);
        conn = 2'b01; wait_n(1);
        chk("R13 inactive when connected", {scl_low, sda_rd}, 3'b000);
        chk("R6 switch m0", sw_en, 2'b01);
        conn = 2'b00; man_scl = 2'b11; man_sda = 2'b11; scl_in = 1'b1;
        drop_all();
    endtask

    task automatic t_countdown_idle();
        write_rt(0, 8'd3);
        idle_en = 2'b01; bus_idle = 1'b1;
        req = 2'b01; wait_n(1);
        chk("R9 rsv at grant", rsv, 8'd3);
        wait_n(3);
        chk("R9 rsv before tick", rsv, 8'd3);
        wait_n(1);
        chk("R9 rsv after tick", rsv, 8'd2);
        wait_n(8);
        chk("R9 rsv expired", rsv, 8'd0);
        wait_n(IDLE - 1);
        chk("R10 grant before timeout", grant, 2'b01);
        wait_n(1);
        chk("R10 revoked", grant, 2'b00);
        chk("R10 lost pulse", lost, 2'b01);
        wait_n(1);
        chk("R10 lost one cycle", lost, 2'b00);
        chk("R11 no regrant while held", grant, 2'b00);
        req = 2'b11; wait_n(1);
        chk("R11 other served", grant, 2'b10);
        req = 2'b01; wait_n(2);
        chk("R11 still locked out", grant, 2'b00);
        req = 2'b00; wait_n(1);
        req = 2'b01; wait_n(1);
        chk("R11 re-raise granted", grant, 2'b01);
        idle_en = 2'b00; bus_idle = 1'b0;
        drop_all();
    endtask

    task automatic t_idle_restart();
        write_rt(0, 8'd0);
        idle_en = 2'b01; bus_idle = 1'b1;
        req = 2'b01; wait_n(1);
        wait_n(199);
        bus_idle = 1'b0; wait_n(1);
        bus_idle = 1'b1;
        wait_n(249);
        chk("R10 busy cycle restarts count", grant, 2'b01);
        wait_n(150);
        chk("R10 grant at restarted limit-1", grant, 2'b01);
        wait_n(1);
        chk("R10 revoked after restart", grant, 2'b00);
        idle_en = 2'b00; bus_idle = 1'b0;
        drop_all();
    endtask

    task automatic t_idle_off();
        idle_en = 2'b00; bus_idle = 1'b1;
        req = 2'b10; wait_n(IDLE + 100);
        chk("R12 no revoke when disabled", grant, 2'b10);
        chk("R12 no lost", lost, 2'b00);
        bus_idle = 1'b0;
        drop_all();
    endtask

    initial begin
        wait_n(1);
        t_reset();
        t_single();
        t_tie();
        t_wait();
        t_rsv_write();
        t_switch();
        t_manual();
        t_countdown_idle();
        t_idle_restart();
        t_idle_off();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule